// File: doc/BRIEF.md
# Two-Channel Programmable Interval Timer with APB Access

This block is a down-counting interval timer on an APB slave port. It holds a small number of channels, two by default. Each channel has a 32-bit count word, a 32-bit reload word and a four-bit control field. A mode value in the control field decides how the count word is used. It can be one 32-bit timer, two 16-bit timers or four 8-bit timers, and every sub-timer reloads from the matching slice of the reload word.

Enable bits, interrupt-enable bits and timeout flags are shared words holding four bits per channel. The bit for channel c, sub-timer i is at position 4*c + i. A sub-timer that passes zero sets its flag, and software clears flags by writing ones. One interrupt line goes high while any flag is set together with its enable bit. Each channel counts either on every PCLK cycle or on rising edges of its own external tick input, which is first brought into the PCLK domain.

Top module: `apb_pit`

## Requirements
- R1: After reset, prdata returns a fixed identifier (default 0x5017_0001) at offset 0x00 and the channel count at 0x10. The interrupt-enable (0x14), flag (0x18) and enable (0x1C) words read zero, as do all per-channel words, and irq is low.
- R2: Per-channel words sit at 0x20 + 0x10*c: control at +0x0, reload at +0x4 and count at +0x8. Control keeps write-data bits [3:0] only and reads back with the upper bits zero. Reload reads back as written.
- R3: With mode 1 (one 32-bit timer) and control bit 3 set (count every PCLK cycle), an enabled count steps down by one per cycle and reads live. One tick after reading zero it reloads and sets its flag, so the period is reload+1 ticks.
- R4: With mode 2, bits [15:0] form sub-timer 0 and bits [31:16] form sub-timer 1. Each counts and reloads from its own reload half, with flag bits 4c and 4c+1.
- R5: With mode 3, the four bytes of the count word, lowest first, form sub-timers 0 to 3. Each reloads from its own reload byte and sets flag bit 4c+i.
- R6: A sub-timer loads its reload slice in the cycle after its enable bit goes from 0 to 1. While its enable bit is 0 it holds its count and never sets its flag.
- R7: A write to the count word presets it, and counting continues down from the written value.
- R8: Writing a 1 to a bit of the flag word clears it. Writing 0 leaves it unchanged.
- R9: irq is high exactly when some flag bit is set together with the interrupt-enable bit at the same position.
- R10: With control bit 3 clear, a channel decrements once per rising edge of its ext_tick bit after a two-flop synchronizer. A level held high counts once.
- R11: Mode values other than 1, 2 and 3 keep all counts of that channel still, apart from direct count writes, and set no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock, also the counting clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| ext_tick | input | NUM_CH | One external count source per channel, asynchronous |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest state to reach from the ports is several sub-timers of one word wrapping at different moments. Part of the word must have reloaded while another part is still counting, and the flag word must show a partial pattern. The bench gets there with a fixed-seed random choice of channel, mode and per-slice reload values, followed by a random wait. It then compares the count word and flag word it reads with a per-slice closed form that uses the number of cycles since the enabling write. Directed sequences cover the external tick edge counting, the idle modes and the flag clear with held counters.

// File: rtl/pit_pkg.sv
// Package: shared constants for the interval timer.
// Assumes a 32-bit count word split into at most four sub-timers.
package pit_pkg;
    localparam int CNT_W  = 32;
    localparam int SUB_N  = 4;
    localparam int HALF_W = CNT_W / 2;
    localparam int BYTE_W = CNT_W / SUB_N;

    localparam logic [2:0] MODE_W32 = 3'd1;
    localparam logic [2:0] MODE_W16 = 3'd2;
    localparam logic [2:0] MODE_W8  = 3'd3;

    localparam int OFS_ID  = 'h00;
    localparam int OFS_CFG = 'h10;
    localparam int OFS_IE  = 'h14;
    localparam int OFS_ST  = 'h18;
    localparam int OFS_EN  = 'h1C;
    localparam int CH_ROW0 = 2;     // channel blocks start at 0x20, 16 bytes each

    localparam logic [1:0] FLD_CTRL   = 2'd0;
    localparam logic [1:0] FLD_RELOAD = 2'd1;
    localparam logic [1:0] FLD_COUNT  = 2'd2;
endpackage

// File: rtl/pit_tick_sync.sv
// Module: two-flop synchronizer plus rising-edge detector for W tick inputs.
// Assumes input pulses stay high and low for at least two clock periods.
module pit_tick_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise
);
    logic [W-1:0] s1, s2, s3;

    // Sample, resynchronize, and keep one older copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '0;
        end else begin
            s1 <= din;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise = s2 & ~s3;
endmodule

// File: rtl/pit_channel.sv
// Module: one timer channel; holds the count word and splits it into
// one, two or four down-counting sub-timers according to the mode.
// Assumes tick is a single-cycle qualifier; a count write overrides all.
module pit_channel
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode,
    input  logic             tick,
    input  logic [SUB_N-1:0] en,
    input  logic [CNT_W-1:0] reload,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [SUB_N-1:0] fire
);
    localparam logic [CNT_W-1:0]  ONE_W = 1;
    localparam logic [HALF_W-1:0] ONE_H = 1;
    localparam logic [BYTE_W-1:0] ONE_B = 1;

    logic [SUB_N-1:0] en_q;
    logic [SUB_N-1:0] rise;
    logic [CNT_W-1:0] nxt;

    assign rise = en & ~en_q;

    // Next count word and wrap pulses for the current mode.
    always_comb begin
        nxt  = cnt;
        fire = '0;
        case (mode)
            MODE_W32: begin
                if (rise[0]) begin
                    nxt = reload;
                end else if (en[0] && tick) begin
                    if (cnt == '0) begin
                        nxt     = reload;
                        fire[0] = 1'b1;
                    end else begin
                        nxt = cnt - ONE_W;
                    end
                end
            end
            MODE_W16: begin
                for (int i = 0; i < 2; i++) begin
                    if (rise[i]) begin
                        nxt[i*HALF_W +: HALF_W] = reload[i*HALF_W +: HALF_W];
                    end else if (en[i] && tick) begin
                        if (cnt[i*HALF_W +: HALF_W] == '0) begin
                            nxt[i*HALF_W +: HALF_W] = reload[i*HALF_W +: HALF_W];
                            fire[i] = 1'b1;
                        end else begin
                            nxt[i*HALF_W +: HALF_W] = cnt[i*HALF_W +: HALF_W] - ONE_H;
                        end
                    end
                end
            end
            MODE_W8: begin
                for (int i = 0; i < SUB_N; i++) begin
                    if (rise[i]) begin
                        nxt[i*BYTE_W +: BYTE_W] = reload[i*BYTE_W +: BYTE_W];
                    end else if (en[i] && tick) begin
                        if (cnt[i*BYTE_W +: BYTE_W] == '0) begin
                            nxt[i*BYTE_W +: BYTE_W] = reload[i*BYTE_W +: BYTE_W];
                            fire[i] = 1'b1;
                        end else begin
                            nxt[i*BYTE_W +: BYTE_W] = cnt[i*BYTE_W +: BYTE_W] - ONE_B;
                        end
                    end
                end
            end
            default: ;
        endcase
    end

    // Register the count word and the previous enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            en_q <= '0;
        end else begin
            en_q <= en;
            cnt  <= cnt_wr ? cnt_wdata : nxt;
        end
    end
endmodule

// File: rtl/apb_pit.sv
// Module: APB interval timer top; register file, channel array, tick
// synchronizer and combined interrupt. Assumes zero-wait APB transfers.
module apb_pit
    import pit_pkg::*;
#(
    parameter int          NUM_CH   = 2,
    parameter int          ADDR_W   = 8,
    parameter logic [31:0] ID_VALUE = 32'h5017_0001
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic [NUM_CH-1:0] ext_tick,
    output logic              irq
);
    localparam int NB = SUB_N * NUM_CH;

    logic                         wr;
    logic                         st_wr;
    logic [NB-1:0]                ie_r, en_r, st_r, fire_all;
    logic [NUM_CH-1:0][3:0]       ctrl_r;
    logic [NUM_CH-1:0][CNT_W-1:0] reload_r;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_all;
    logic [NUM_CH-1:0][2:0]       mode_all;
    logic [NUM_CH-1:0]            hit, cnt_wr, tick, ext_rise;

    assign wr    = psel & penable & pwrite;
    assign st_wr = wr && (paddr == ADDR_W'(OFS_ST));

    pit_tick_sync #(.W(NUM_CH)) u_sync (
        .clk   (pclk),
        .rst_n (presetn),
        .din   (ext_tick),
        .rise  (ext_rise)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign hit[c]      = (paddr[ADDR_W-1:4] == (ADDR_W-4)'(CH_ROW0 + c));
        assign mode_all[c] = ctrl_r[c][2:0];
        assign tick[c]     = ctrl_r[c][3] ? 1'b1 : ext_rise[c];
        assign cnt_wr[c]   = wr && hit[c] && (paddr[3:2] == FLD_COUNT);

        pit_channel u_ch (
            .clk       (pclk),
            .rst_n     (presetn),
            .mode      (mode_all[c]),
            .tick      (tick[c]),
            .en        (en_r[c*SUB_N +: SUB_N]),
            .reload    (reload_r[c]),
            .cnt_wr    (cnt_wr[c]),
            .cnt_wdata (pwdata),
            .cnt       (cnt_all[c]),
            .fire      (fire_all[c*SUB_N +: SUB_N])
        );
    end

    // Shared enable, interrupt-enable and write-one-to-clear flag words.
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            ie_r <= '0;
            en_r <= '0;
            st_r <= '0;
        end else begin
            if (wr && paddr == ADDR_W'(OFS_IE)) ie_r <= pwdata[NB-1:0];
            if (wr && paddr == ADDR_W'(OFS_EN)) en_r <= pwdata[NB-1:0];
            st_r <= (st_r & ~(st_wr ? pwdata[NB-1:0] : '0)) | fire_all;
        end
    end

    // Per-channel control and reload words.
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            ctrl_r   <= '0;
            reload_r <= '0;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (wr && hit[c] && paddr[3:2] == FLD_CTRL)   ctrl_r[c]   <= pwdata[3:0];
                if (wr && hit[c] && paddr[3:2] == FLD_RELOAD) reload_r[c] <= pwdata;
            end
        end
    end

    // Read data multiplexer.
    always_comb begin
        prdata = '0;
        if (paddr == ADDR_W'(OFS_ID))  prdata = ID_VALUE;
        if (paddr == ADDR_W'(OFS_CFG)) prdata = 32'(NUM_CH);
        if (paddr == ADDR_W'(OFS_IE))  prdata[NB-1:0] = ie_r;
        if (paddr == ADDR_W'(OFS_ST))  prdata[NB-1:0] = st_r;
        if (paddr == ADDR_W'(OFS_EN))  prdata[NB-1:0] = en_r;
        for (int c = 0; c < NUM_CH; c++) begin
            if (hit[c]) begin
                case (paddr[3:2])
                    FLD_CTRL:   prdata = {28'd0, ctrl_r[c]};
                    FLD_RELOAD: prdata = reload_r[c];
                    FLD_COUNT:  prdata = cnt_all[c];
                    default:    prdata = '0;
                endcase
            end
        end
    end

    assign irq = |(st_r & ie_r);
endmodule

// File: rtl/pit_checker.sv
// Module: temporal checks on the timer's flags, interrupt and counters.
// Attached to every apb_pit instance by the bind at the end of this file.
module pit_checker #(
    parameter int NUM_CH = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    irq,
    input logic [4*NUM_CH-1:0]     st,
    input logic [4*NUM_CH-1:0]     ie,
    input logic [4*NUM_CH-1:0]     en,
    input logic                    st_wr,
    input logic [31:0]             wdata,
    input logic [NUM_CH-1:0][2:0]  mode,
    input logic [NUM_CH-1:0][31:0] cnt,
    input logic [NUM_CH-1:0]       cnt_wr
);
    localparam int NB = 4 * NUM_CH;

    // R9: no interrupt while every enable bit is clear.
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == '0) |-> !irq);

    for (genvar k = 0; k < NB; k++) begin : g_bit
        // R8: a flag only falls after a write of one to its position.
        p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(st[k]) |-> $past(st_wr && wdata[k]));
        // R6: a flag only rises for an enabled sub-timer.
        p_flag_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st[k]) |-> $past(en[k]));
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        // R11: an unsupported mode keeps the count word still.
        p_idle_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (!(mode[c] inside {3'd1, 3'd2, 3'd3}) && !cnt_wr[c]) |=> $stable(cnt[c]));
        // R6: a disabled 32-bit timer holds its count.
        p_hold_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[c] == 3'd1 && !en[4*c] && !cnt_wr[c]) |=> $stable(cnt[c]));
    end
endmodule

bind apb_pit pit_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk    (pclk),
    .rst_n  (presetn),
    .irq    (irq),
    .st     (st_r),
    .ie     (ie_r),
    .en     (en_r),
    .st_wr  (st_wr),
    .wdata  (pwdata),
    .mode   (mode_all),
    .cnt    (cnt_all),
    .cnt_wr (cnt_wr)
);

// File: tb/apb_pit_test.sv
// Bench: directed and seeded-random checks of apb_pit through its APB port.
module apb_pit_test;
    localparam logic [31:0] ID_EXP = 32'h5017_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [1:0]  ext_tick = '0;
    logic        irq;
    int          cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    apb_pit uut (
        .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .ext_tick(ext_tick), .irq(irq)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_e(input logic [7:0] a, input logic [31:0] d, output int e);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk); penable = 1; e = cyc + 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        int e;
        wr_e(a, d, e);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output int sc);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk); penable = 1; #1 d = prdata; sc = cyc;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    function automatic logic [7:0] chadr(input int c, input int f);
        return 8'(32 + 16 * c + 4 * f);
    endfunction

    // Expected count word k ticks after the enable load, per slice.
    function automatic logic [31:0] exp_cnt(input int m, input logic [31:0] rl, input int k);
        int lanes = (m == 1) ? 1 : (m == 2) ? 2 : 4;
        int w = 32 / lanes;
        longint mask = (64'd1 << w) - 1;
        logic [31:0] res = '0;
        for (int i = 0; i < lanes; i++) begin
            longint r = (longint'(rl) >> (i * w)) & mask;
            longint v = r - (longint'(k) % (r + 1));
            res = res | 32'(v << (i * w));
        end
        return res;
    endfunction

    function automatic logic [3:0] exp_st(input int m, input logic [31:0] rl, input int k);
        int lanes = (m == 1) ? 1 : (m == 2) ? 2 : 4;
        int w = 32 / lanes;
        longint mask = (64'd1 << w) - 1;
        logic [3:0] res = '0;
        for (int i = 0; i < lanes; i++) begin
            longint r = (longint'(rl) >> (i * w)) & mask;
            res[i] = (longint'(k) >= r + 1);
        end
        return res;
    endfunction

    task automatic pulse(input int c, input int hi, input int lo);
        @(negedge clk); ext_tick[c] = 1'b1;
        repeat (hi) @(negedge clk);
        ext_tick[c] = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d, d2;
        int sc, sc2, e, w;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(8'h00, d, sc); chk("R1 id", d, ID_EXP);
        rd(8'h10, d, sc); chk("R1 cfg", d, 32'd2);
        rd(8'h14, d, sc); chk("R1 ie", d, 0);
        rd(8'h18, d, sc); chk("R1 status", d, 0);
        rd(8'h1C, d, sc); chk("R1 enable", d, 0);
        rd(chadr(1, 2), d, sc); chk("R1 count", d, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2: per-channel layout and control width
        wr(chadr(1, 1), 32'hA5A5_1234);
        wr(chadr(1, 0), 32'hFFFF_FFFB);
        rd(chadr(1, 1), d, sc); chk("R2 reload", d, 32'hA5A5_1234);
        rd(chadr(1, 0), d, sc); chk("R2 ctrl", d, 32'h0000_000B);
        rd(chadr(0, 1), d, sc); chk("R2 other channel", d, 0);
        wr(chadr(1, 0), 0); wr(chadr(1, 1), 0);

        // R3: 32-bit mode on PCLK, live reads and wrap
        wr(chadr(0, 0), 32'h9);
        wr(chadr(0, 1), 32'd10);
        wr_e(8'h1C, 32'h1, e);
        for (int j = 0; j < 3; j++) begin
            rd(chadr(0, 2), d, sc);
            chk("R3 count", d, exp_cnt(1, 10, sc - (e + 1)));
        end
        rd(8'h18, d, sc); chk("R3 status", d, {28'd0, exp_st(1, 10, sc - (e + 1))});
        repeat (12) @(negedge clk);
        rd(8'h18, d, sc); chk("R3 status set", d, 32'h1);

        // R9: interrupt masking by bit position
        chk("R9 masked", {31'd0, irq}, 0);
        wr(8'h14, 32'h10); chk("R9 other bit", {31'd0, irq}, 0);
        wr(8'h14, 32'h01); chk("R9 raised", {31'd0, irq}, 1);

        // R8: write-one-to-clear with the channel stopped
        wr(8'h1C, 32'h0);
        repeat (3) @(negedge clk);
        wr(8'h18, 32'h0);
        rd(8'h18, d, sc); chk("R8 zero write keeps", d, 32'h1);
        wr(8'h18, 32'h1);
        rd(8'h18, d, sc); chk("R8 one write clears", d, 0);
        chk("R9 dropped", {31'd0, irq}, 0);

        // R6: hold while disabled, load on enable edge
        rd(chadr(0, 2), d, sc);
        wr(chadr(0, 1), 32'd50);
        repeat (20) @(negedge clk);
        rd(chadr(0, 2), d2, sc2); chk("R6 hold", d2, d);
        wr_e(8'h1C, 32'h1, e);
        rd(chadr(0, 2), d, sc); chk("R6 load", d, exp_cnt(1, 50, sc - (e + 1)));

        // R7: preset through the count word
        wr_e(chadr(0, 2), 32'd1000, w);
        rd(chadr(0, 2), d, sc); chk("R7 preset", d, 32'(1000 - (sc - w)));
        wr(8'h1C, 0); wr(8'h18, 32'hFF); wr(8'h14, 0);

        // R10: external tick edges on channel 1
        wr(chadr(1, 0), 32'h1);
        wr(chadr(1, 1), 32'd20);
        wr(8'h1C, 32'h10);
        repeat (6) @(negedge clk);
        rd(chadr(1, 2), d, sc); chk("R10 no edges", d, 32'd20);
        for (int j = 0; j < 5; j++) pulse(1, 3, 3);
        pulse(0, 3, 3);
        repeat (4) @(negedge clk);
        rd(chadr(1, 2), d, sc); chk("R10 five edges", d, 32'd15);
        pulse(1, 12, 4);
        rd(chadr(1, 2), d, sc); chk("R10 long level", d, 32'd14);

        // R11: unsupported modes stay idle
        wr(chadr(1, 0), 32'h8);
        wr(chadr(1, 2), 32'h77);
        repeat (30) @(negedge clk);
        rd(chadr(1, 2), d, sc); chk("R11 mode 0", d, 32'h77);
        wr(chadr(1, 0), 32'h8 | (4 + $urandom % 4));
        repeat (30) @(negedge clk);
        rd(chadr(1, 2), d, sc); chk("R11 high mode", d, 32'h77);
        rd(8'h18, d, sc); chk("R11 no flags", d, 0);
        wr(8'h1C, 0);

        // R3/R4/R5: random channel, mode and slice reloads
        for (int it = 0; it < 18; it++) begin
            int c = int'($urandom % 2);
            int m = 1 + int'($urandom % 3);
            logic [31:0] rl;
            logic [3:0] msk;
            string tag;
            if (m == 1) begin
                rl = 2 + $urandom % 199; msk = 4'h1; tag = "R3 rand";
            end else if (m == 2) begin
                rl = {16'(1 + $urandom % 60), 16'(1 + $urandom % 60)};
                msk = 4'h3; tag = "R4 rand";
            end else begin
                rl = {8'(1 + $urandom % 40), 8'(1 + $urandom % 40),
                      8'(1 + $urandom % 40), 8'(1 + $urandom % 40)};
                msk = 4'hF; tag = "R5 rand";
            end
            wr(chadr(c, 0), 32'h8 | 32'(m));
            wr(chadr(c, 1), rl);
            wr_e(8'h1C, 32'(msk) << (4 * c), e);
            repeat ($urandom % 150) @(negedge clk);
            rd(chadr(c, 2), d, sc);
            chk(tag, d, exp_cnt(m, rl, sc - (e + 1)));
            rd(8'h18, d, sc);
            chk({tag, " status"}, d, 32'(exp_st(m, rl, sc - (e + 1))) << (4 * c));
            wr(8'h1C, 0);
            wr(8'h18, 32'hFF);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule